// File: doc/BRIEF.md
# Masked Bit-Manipulation Execution Unit

This unit carries out one bit-manipulation operation on two operands of XLEN bits. A mask is formed first. It is either the full width or the second operand, chosen by a flag that reports whether the second source register number was zero. Two terms are then built from the first operand. One is the operand limited by the mask, or its full inverse. The other is one of four arithmetic variants: negate, decrement, increment, or the inverse of the increment. Both terms are limited by the mask and joined by OR, AND or XOR. The joined value is limited by the mask again. An optional restore step then fills the bits outside the mask from the first operand.

The unit sits in an execution pipeline with one register stage. A pulse on `in_valid` captures the operation. The result appears with `out_valid` on the next clock. One operator code has no defined meaning. For that code the unit returns zero and raises `illegal` alongside the result.

Top module: `mask_bitop_unit`

## Requirements
- R1: When `b_is_zero` is 1 the mask is all ones, whatever `src_b` holds. When `b_is_zero` is 0 the mask equals `src_b`.
- R2: The first term is `~src_a` when `mode[0]` is 1, and `src_a & mask` when `mode[0]` is 0.
- R3: `mode[2:1]` picks the second term from `src_a`: 0 gives `-src_a`, 1 gives `src_a-1`, 2 gives `src_a+1`, 3 gives `~(src_a+1)`.
- R4: Both terms, and the joined value, are ANDed with the mask. With `restore` at 0, every result bit outside the mask is 0.
- R5: `mode[4:3]` picks how the terms are joined: 0 is OR, 1 is AND, 2 is XOR.
- R6: When `mode[4:3]` is 3 the result is all zeros, `restore` is ignored, and `illegal` is 1 in the same cycle as `out_valid`. For every other code `illegal` is 0.
- R7: When `restore` is 1 and the operator code is legal, result bits outside the mask equal the matching bits of `src_a`.
- R8: `out_valid` is 1 exactly one clock after a cycle with `in_valid` at 1, and the result comes with it. In all other cycles `out_valid` is 0.
- R9: Synchronous active-high `rst` clears `out_valid`, `result` and `illegal`. After a cycle without `in_valid`, `result` and `illegal` keep their previous values.
- R10: Arithmetic wraps modulo 2^XLEN, so incrementing all ones gives 0 and decrementing 0 gives all ones. No carry output exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Captures an operation this cycle |
| src_a | input | XLEN | First operand |
| src_b | input | XLEN | Mask operand |
| b_is_zero | input | 1 | Second source register number is zero; selects the full mask |
| mode | input | 5 | [0] invert, [2:1] arithmetic select, [4:3] operator select |
| restore | input | 1 | Fill bits outside the mask from `src_a` |
| out_valid | output | 1 | Result valid |
| result | output | XLEN | Operation result |
| illegal | output | 1 | Undefined operator code was used |

## Verification
The hardest case to reach is one where the inverted first term, the restore merge and the wraparound of the arithmetic term all matter in one result. This needs a partial mask whose upper bits differ from `src_a`, together with operands at all zeros or all ones. The stimulus sweeps all 32 mode values with both restore settings against five operand patterns: all zero, all one, an empty mask, a full mask forced by `b_is_zero`, and random operands. Idle cycles are mixed in so that the hold and valid timing are checked between operations.

// File: rtl/mask_bitop_unit.sv
module mask_bitop_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic            b_is_zero,
  input  logic [4:0]      mode,
  input  logic            restore,
  output logic            out_valid,
  output logic [XLEN-1:0] result,
  output logic            illegal
);
  localparam logic [XLEN-1:0] ALL_ONES = '1;
  localparam logic [XLEN-1:0] UNIT     = XLEN'(1);

  logic [XLEN-1:0] mask, term_a, term_b, joined, merged;
  logic            bad_op;

  assign mask   = b_is_zero ? ALL_ONES : src_b;
  assign term_a = (mode[0] ? ~src_a : src_a) & mask;

  always_comb begin
    case (mode[2:1])
      2'd0:    term_b = ~src_a + UNIT;
      2'd1:    term_b = src_a - UNIT;
      2'd2:    term_b = src_a + UNIT;
      default: term_b = ~(src_a + UNIT);
    endcase
  end

  always_comb begin
    case (mode[4:3])
      2'd0:    joined = term_a | (term_b & mask);
      2'd1:    joined = term_a & (term_b & mask);
      2'd2:    joined = term_a ^ (term_b & mask);
      default: joined = '0;
    endcase
  end

  assign bad_op = &mode[4:3];
  assign merged = bad_op ? '0 : ((joined & mask) | (restore ? (src_a & ~mask) : '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= merged;
        illegal <= bad_op;
      end
    end
  end
endmodule

// File: rtl/mask_bitop_unit_chk.sv
module mask_bitop_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [XLEN-1:0] src_a,
  input logic [XLEN-1:0] src_b,
  input logic            b_is_zero,
  input logic [4:0]      mode,
  input logic            restore,
  input logic            out_valid,
  input logic [XLEN-1:0] result,
  input logic            illegal
);
  logic [XLEN-1:0] cmask;
  assign cmask = b_is_zero ? {XLEN{1'b1}} : src_b;

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_illegal_flag_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (illegal == ($past(mode[4:3]) == 2'b11)));
  assert_illegal_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && illegal) |-> (result == '0));
  assert_masked_off_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !restore) |=> ((result & ~$past(cmask)) == '0));
  assert_restore_bits_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && restore && mode[4:3] != 2'b11)
      |=> ((result & ~$past(cmask)) == ($past(src_a) & ~$past(cmask))));
  assert_hold_result_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(illegal)));
endmodule

bind mask_bitop_unit mask_bitop_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/mask_bitop_unit_tb.sv
module mask_bitop_unit_tb;
  localparam int XLEN = 64;
  localparam int CLK_PERIOD = 10;
  localparam logic [XLEN-1:0] ONES = {XLEN{1'b1}};

  logic            clk = 0;
  logic            rst = 1;
  logic            in_valid = 0;
  logic [XLEN-1:0] src_a = '0, src_b = '0;
  logic            b_is_zero = 0;
  logic [4:0]      mode = '0;
  logic            restore = 0;
  logic            out_valid, illegal;
  logic [XLEN-1:0] result;

  int checks = 0;
  int errors = 0;

  bit              exp_valid = 0;
  logic [XLEN-1:0] exp_res = '0;
  bit              exp_ill = 0;
  logic [XLEN-1:0] held_res = '0;
  bit              held_ill = 0;
  string           exp_tag = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  mask_bitop_unit #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .b_is_zero(b_is_zero), .mode(mode), .restore(restore),
    .out_valid(out_valid), .result(result), .illegal(illegal)
  );

  function automatic logic [XLEN-1:0] model(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                                            input bit bz, input logic [4:0] md, input bit l,
                                            output bit ill);
    logic [XLEN-1:0] m, x, y, z;
    int op, ar;
    m  = bz ? ONES : b;
    op = int'(md[4:3]);
    ar = int'(md[2:1]);
    x  = md[0] ? ~a : a;
    x  = x & m;
    if (ar == 0)      y = '0 - a;
    else if (ar == 1) y = a + ONES;
    else if (ar == 2) y = a - ONES;
    else              y = ('0 - a) - XLEN'(2);
    y = y & m;
    ill = (op == 3);
    if (ill) return '0;
    if (op == 0)      z = x | y;
    else if (op == 1) z = x & y;
    else              z = x ^ y;
    z = z & m;
    if (l) z = z | (a & ~m);
    return z;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic step(input bit v, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                      input bit bz, input logic [4:0] md, input bit l, input string tag);
    bit ill;
    logic [XLEN-1:0] r;
    in_valid = v; src_a = a; src_b = b; b_is_zero = bz; mode = md; restore = l;
    r = model(a, b, bz, md, l, ill);
    @(negedge clk);
    if (v) begin
      check(out_valid === 1'b1, "R8 valid", XLEN'(out_valid), XLEN'(1));
      check(result === r, tag, result, r);
      check(illegal === ill, "R6 flag", XLEN'(illegal), XLEN'(ill));
      held_res = r; held_ill = ill;
    end else begin
      check(out_valid === 1'b0, "R8 idle", XLEN'(out_valid), '0);
      check(result === held_res, "R9 hold", result, held_res);
      check(illegal === held_ill, "R9 hold flag", XLEN'(illegal), XLEN'(held_ill));
    end
  endtask

  function automatic logic [XLEN-1:0] rnd();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [XLEN-1:0] a, b;
    bit bz;
    string tg;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R9 reset valid", XLEN'(out_valid), '0);
    check(result === '0, "R9 reset result", result, '0);
    check(illegal === 1'b0, "R9 reset flag", XLEN'(illegal), '0);
    rst = 0;

    // R1: b_is_zero overrides garbage in src_b
    step(1, 64'hF0F0_0000_1234_5678, 64'h0000_0000_0000_00FF, 1, 5'b00000, 0, "R1");
    step(1, 64'hF0F0_0000_1234_5678, 64'h0000_0000_0000_00FF, 0, 5'b00000, 0, "R1");
    // R2: inverted first term
    step(1, 64'h0123_4567_89AB_CDEF, 64'h00FF_FF00_FFFF_0000, 0, 5'b10001, 1, "R2");
    // R3: each arithmetic variant
    for (int k = 0; k < 4; k++)
      step(1, 64'h0000_0000_0000_0010, ONES, 0, 5'(k << 1) | 5'b10000, 0, "R3");
    // R4: empty mask leaves nothing without restore
    step(1, ONES, '0, 0, 5'b00101, 0, "R4");
    // R6: illegal operator with restore requested
    step(1, 64'hDEAD_BEEF_0000_1111, 64'hFF, 0, 5'b11011, 1, "R6");
    // R7: restore with empty mask returns src_a
    step(1, 64'hCAFE_F00D_1357_9BDF, '0, 0, 5'b01010, 1, "R7");
    // R10: wraparound
    step(1, ONES, '0, 1, 5'b00100, 0, "R10");
    step(1, '0, '0, 1, 5'b00010, 0, "R10");
    step(0, '0, '0, 0, '0, 0, "R9");
    step(0, ONES, ONES, 1, 5'b01111, 1, "R9");

    // R5 R6 R7 sweep of all modes, both restore settings, five operand patterns
    for (int md = 0; md < 32; md++)
      for (int l = 0; l < 2; l++)
        for (int p = 0; p < 5; p++) begin
          a = rnd(); b = rnd(); bz = 0;
          if (p == 0) begin a = '0; b = rnd(); end
          if (p == 1) begin a = ONES; b = rnd(); end
          if (p == 2) b = '0;
          if (p == 3) bz = 1;
          tg = (md >= 24) ? "R6" : (l == 1 ? "R7" : "R5");
          step(1, a, b, bz, 5'(md), bit'(l), tg);
          if (p == 4 && md % 4 == 0) step(0, rnd(), rnd(), 0, 5'(md), 0, "R8");
        end

    for (int n = 0; n < 400; n++)
      step(bit'($urandom % 4 != 0), rnd(), rnd(), bit'($urandom % 5 == 0),
           5'($urandom), bit'($urandom), "R5");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule